// File: doc/BRIEF.md
# Dual-Channel Disk Controller Register File

This block is the control and status register file of a two-channel disk host controller. A simple synchronous register bus reaches it with a 9-bit byte address, 32-bit data, a read strobe, a write strobe and four byte enables. For each channel it stores three registers: a 6-bit soft-data register, a 12-bit serial control register and a masked 16-bit interrupt enable register. It also builds a read-only configuration/status word for each channel, whose interrupt bit follows that channel's interrupt level input.

The bus-master DMA command, status and descriptor-address registers live outside the block. Their current values arrive as inputs and are returned on reads. A write to one of them produces a one-cycle strobe, and the external logic then takes the data and byte enables straight from the bus. Two summary words pack the DMA bytes and interrupt bits of both channels, so software can collect them in one access. A write that sets bit 0 of a serial control register also sends a one-cycle reset request to that channel. The interrupt output is the OR of the two channels' interrupt bits.

Data for a byte register is right-justified on the bus in byte lane 0. Every read returns its data one clock after the read strobe, and the read data then holds until the next read.

Top module: `dchan_regfile`

## Requirements
- R1: After reset:
  - read data, irq_o and all strobes are 0;
  - the soft-data, serial control and interrupt enable registers are 0;
  - each configuration/status word reads 0x65150000.
- R2: The soft-data register stores bits 5:0 of a write that has bus_be[0] set.
  - Channel 0 accepts writes at 0x01 and 0x11; channel 1 at 0x09 and 0x19.
  - It reads back at 0x01 (ch 0) and 0x09 (ch 1) with the upper bits zero. A read at 0x11 or 0x19 returns 0.
- R3: The serial control register sits at 0x100 (ch 0) and 0x180 (ch 1) and stores bits 11:0 of a write.
  - Bits 7:0 are written only when bus_be[0] is set, and bits 11:8 only when bus_be[1] is set.
- R4: A write to a serial control register with bus_be[0] set and data bit 0 set drives that channel's chan_rst_o bit high for exactly the one cycle after the write edge.
- R5: The interrupt enable register sits at 0x148 (ch 0) and 0x1C8 (ch 1). It stores bits 31:16 of the write ANDed with 0x3EED, under byte enables 2 and 3, and reads back in bits 31:16.
- R6: The configuration/status word reads at 0xA0 (ch 0) and 0xE0 (ch 1) as 0x6515 in bits 31:16 and zero elsewhere, except bit 11. Bit 11 equals that channel's irq_lvl_i bit as sampled at the previous clock edge.
- R7: irq_o is the OR of both channels' bit 11, so it is high one cycle after either irq_lvl_i bit is high.
- R8: A read at 0x10 returns the following fields:
  - bits 7:0: the channel 0 DMA command byte, with bit 4 ORed with channel 0's bit 11 and bit 6 ORed with channel 1's bit 11;
  - bit 14: bit 2 (the interrupt flag) of the channel 1 DMA status;
  - bits 23:16: the channel 0 DMA status;
  - bits 31:24: the channel 1 DMA status.
- R9: A read at 0x18 returns the channel 1 DMA command byte in bits 7:0, with bit 4 ORed with channel 1's bit 11, and the channel 1 DMA status in bits 23:16.
- R10: The link status word at 0x104 (ch 0) and 0x184 (ch 1) reads 0x113 while that channel's drive_present_i bit is high and 0 otherwise.
- R11: Reads pass the external DMA values through:
  - command at 0x00 and 0x08, status at 0x02 and 0x0A, descriptor address at 0x04 and 0x0C;
  - offsets 0x03 and 0x0B read 0.
- R12: With bus_be[0] set, a write to 0x00 or 0x10 pulses dma_cmd_we_o[0], and a write to 0x08 or 0x18 pulses dma_cmd_we_o[1]. Likewise, 0x02 or 0x12 pulses dma_sts_we_o[0], and 0x0A or 0x1A pulses dma_sts_we_o[1]. Any write to 0x04 pulses dma_prd_we_o[0], and any write to 0x0C pulses dma_prd_we_o[1]. Each pulse lasts exactly one cycle after the write edge.
- R13: A read of an unmapped offset returns 0. A write to an unmapped offset changes no register and raises no strobe.
- R14: bus_rdata takes the addressed value on the clock edge that samples bus_rd, and holds it while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dma_cmd_i | input | 16 | DMA command bytes, channel 1 in the upper byte |
| dma_sts_i | input | 16 | DMA status bytes, channel 1 in the upper byte |
| dma_prd_i | input | 64 | DMA descriptor addresses, channel 1 in the upper word |
| drive_present_i | input | 2 | Drive present, one bit per channel |
| irq_lvl_i | input | 2 | Interrupt level, one bit per channel |
| dma_cmd_we_o | output | 2 | DMA command write strobes |
| dma_sts_we_o | output | 2 | DMA status write strobes |
| dma_prd_we_o | output | 2 | DMA address write strobes |
| chan_rst_o | output | 2 | Channel reset requests |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters. These are a 9-bit address, a 6-bit soft-data register, a 12-bit serial control register and the 0x3EED enable mask. With them every mapped offset, both channels and their aliases can be reached, and so can the lane-split writes. Masked bits outside 0x3EED and the dropped upper bits of the soft-data register become visible on readback. The summary words are read with DMA status and interrupt levels chosen so that each packed bit is set in one access and clear in another.

// File: rtl/dchan_regfile.sv
module dchan_regfile #(
  parameter int          AW        = 9,
  parameter int          SWD_W     = 6,
  parameter int          SCTL_W    = 12,
  parameter logic [15:0] SIEN_MASK = 16'h3EED,
  parameter logic [15:0] CFG_ID    = 16'h6515,
  parameter logic [31:0] LINK_UP   = 32'h0000_0113,
  parameter int          INT_BIT   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [3:0]    bus_be,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [15:0]   dma_cmd_i,
  input  logic [15:0]   dma_sts_i,
  input  logic [63:0]   dma_prd_i,
  input  logic [1:0]    drive_present_i,
  input  logic [1:0]    irq_lvl_i,
  output logic [1:0]    dma_cmd_we_o,
  output logic [1:0]    dma_sts_we_o,
  output logic [1:0]    dma_prd_we_o,
  output logic [1:0]    chan_rst_o,
  output logic          irq_o
);

  localparam logic [AW-1:0] A_SUM0 = AW'(16);
  localparam logic [AW-1:0] A_SUM1 = AW'(24);

  logic [31:0]       wmask;
  logic [1:0][31:0]  ch_rd;
  logic [1:0]        cint;
  logic [31:0]       top_rd;

  assign wmask = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};

  for (genvar c = 0; c < 2; c++) begin : g_ch
    localparam logic [AW-1:0] A_CMD  = AW'(8*c);
    localparam logic [AW-1:0] A_CMDA = AW'(16 + 8*c);
    localparam logic [AW-1:0] A_SWD  = AW'(1 + 8*c);
    localparam logic [AW-1:0] A_SWDA = AW'(17 + 8*c);
    localparam logic [AW-1:0] A_STS  = AW'(2 + 8*c);
    localparam logic [AW-1:0] A_STSA = AW'(18 + 8*c);
    localparam logic [AW-1:0] A_PRD  = AW'(4 + 8*c);
    localparam logic [AW-1:0] A_CFG  = AW'(160 + 64*c);
    localparam logic [AW-1:0] A_SCTL = AW'(256 + 128*c);
    localparam logic [AW-1:0] A_LINK = AW'(260 + 128*c);
    localparam logic [AW-1:0] A_SIEN = AW'(328 + 128*c);

    logic [SWD_W-1:0]  swd_q;
    logic [SCTL_W-1:0] sctl_q;
    logic [15:0]       sien_q;
    logic              int_q, rst_q, cmd_we_q, sts_we_q, prd_we_q;
    logic [31:0]       rd_v;
    logic              lane0_wr;

    assign lane0_wr = bus_wr && bus_be[0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        swd_q    <= '0;
        sctl_q   <= '0;
        sien_q   <= '0;
        int_q    <= 1'b0;
        rst_q    <= 1'b0;
        cmd_we_q <= 1'b0;
        sts_we_q <= 1'b0;
        prd_we_q <= 1'b0;
      end else begin
        int_q    <= irq_lvl_i[c];
        rst_q    <= lane0_wr && bus_addr == A_SCTL && bus_wdata[0];
        cmd_we_q <= lane0_wr && (bus_addr == A_CMD || bus_addr == A_CMDA);
        sts_we_q <= lane0_wr && (bus_addr == A_STS || bus_addr == A_STSA);
        prd_we_q <= bus_wr && bus_addr == A_PRD;
        if (lane0_wr && (bus_addr == A_SWD || bus_addr == A_SWDA))
          swd_q <= bus_wdata[SWD_W-1:0];
        if (bus_wr && bus_addr == A_SCTL)
          sctl_q <= (sctl_q & ~wmask[SCTL_W-1:0]) | (bus_wdata[SCTL_W-1:0] & wmask[SCTL_W-1:0]);
        if (bus_wr && bus_addr == A_SIEN)
          sien_q <= (sien_q & ~wmask[31:16]) | (bus_wdata[31:16] & wmask[31:16] & SIEN_MASK);
      end
    end

    always_comb begin
      rd_v = '0;
      if (bus_addr == A_CMD)  rd_v = {24'b0, dma_cmd_i[8*c +: 8]};
      if (bus_addr == A_SWD)  rd_v = 32'(swd_q);
      if (bus_addr == A_STS)  rd_v = {24'b0, dma_sts_i[8*c +: 8]};
      if (bus_addr == A_PRD)  rd_v = dma_prd_i[32*c +: 32];
      if (bus_addr == A_CFG)  rd_v = {CFG_ID, 4'b0, int_q, 11'b0};
      if (bus_addr == A_SCTL) rd_v = 32'(sctl_q);
      if (bus_addr == A_LINK) rd_v = drive_present_i[c] ? LINK_UP : 32'b0;
      if (bus_addr == A_SIEN) rd_v = {sien_q, 16'b0};
    end

    assign ch_rd[c]        = rd_v;
    assign cint[c]         = int_q;
    assign chan_rst_o[c]   = rst_q;
    assign dma_cmd_we_o[c] = cmd_we_q;
    assign dma_sts_we_o[c] = sts_we_q;
    assign dma_prd_we_o[c] = prd_we_q;

    // R4
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |-> sctl_q[0]);
    // R5
    sien_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_wr && bus_addr == A_SIEN && bus_be[3:2] == 2'b11)
      |-> sien_q == ($past(bus_wdata[31:16]) & SIEN_MASK));
    // R12
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_we_q, sts_we_q, prd_we_q, rst_q}));
  end

  always_comb begin
    top_rd = '0;
    if (bus_addr == A_SUM0)
      top_rd = {dma_sts_i[15:8], dma_sts_i[7:0], 1'b0, dma_sts_i[8+INT_BIT], 6'b0,
                dma_cmd_i[7:0] | {1'b0, cint[1], 1'b0, cint[0], 4'b0}};
    if (bus_addr == A_SUM1)
      top_rd = {8'b0, dma_sts_i[15:8], 8'b0, dma_cmd_i[15:8] | {3'b0, cint[1], 4'b0}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= ch_rd[0] | ch_rd[1] | top_rd;
  end

  assign irq_o = |cint;

  // R7
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_lvl_i) |=> irq_o);
  // R7
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|irq_lvl_i) |=> !irq_o);
  // R11
  zero_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && (bus_addr == AW'(3) || bus_addr == AW'(11))) |-> bus_rdata == 32'b0);
  // R14
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));

endmodule

// File: tb/test_dchan_regfile.sv
module test_dchan_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [8:0]  bus_addr = '0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] dma_cmd_i = '0, dma_sts_i = '0;
  logic [63:0] dma_prd_i = '0;
  logic [1:0]  drive_present_i = '0, irq_lvl_i = '0;
  logic [1:0]  dma_cmd_we_o, dma_sts_we_o, dma_prd_we_o, chan_rst_o;
  logic        irq_o;

  int errors = 0, checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;
  logic        done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dchan_regfile i_dchan_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_cmd_i(dma_cmd_i), .dma_sts_i(dma_sts_i), .dma_prd_i(dma_prd_i),
    .drive_present_i(drive_present_i), .irq_lvl_i(irq_lvl_i),
    .dma_cmd_we_o(dma_cmd_we_o), .dma_sts_we_o(dma_sts_we_o), .dma_prd_we_o(dma_prd_we_o),
    .chan_rst_o(chan_rst_o), .irq_o(irq_o));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_rd && rst_n;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wr = 1; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 0; bus_be = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 rdata", bus_rdata, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 strobes", {24'b0, dma_cmd_we_o, dma_sts_we_o, dma_prd_we_o, chan_rst_o}, 0);
    rd(9'h0A0, 32'h6515_0000, "R1 cfg0");
    rd(9'h0E0, 32'h6515_0000, "R1 cfg1");
    rd(9'h100, 0, "R1 sctl0");
    rd(9'h1C8, 0, "R1 sien1");
    rd(9'h001, 0, "R1 swd0");

    // R2
    wr(9'h001, 32'hFFFF_FFFF, 4'hF);
    rd(9'h001, 32'h3F, "R2 swd0 mask");
    wr(9'h019, 32'h0000_002A, 4'h1);
    rd(9'h009, 32'h2A, "R2 swd1 alias");
    rd(9'h011, 0, "R2 alias read zero");
    wr(9'h009, 32'h15, 4'hE);
    rd(9'h009, 32'h2A, "R2 no lane0 ignored");

    // R3
    wr(9'h100, 32'hFFFF_F5A0, 4'hF);
    check("R3 no rst on bit0 clear", {30'b0, chan_rst_o}, 0);
    rd(9'h100, 32'h0000_05A0, "R3 sctl0 12 bits");
    wr(9'h180, 32'h0000_0FFF, 4'h1);
    rd(9'h180, 32'h0000_00FF, "R3 sctl1 lane0 only");

    // R4
    wr(9'h180, 32'h0000_0001, 4'h1);
    check("R4 rst pulse", {30'b0, chan_rst_o}, 32'h2);
    @(negedge clk);
    check("R4 rst one cycle", {30'b0, chan_rst_o}, 0);

    // R5
    wr(9'h148, 32'hFFFF_0000, 4'hF);
    rd(9'h148, 32'h3EED_0000, "R5 sien0 mask");
    wr(9'h1C8, 32'h1234_5678, 4'hF);
    rd(9'h1C8, {16'h1234 & 16'h3EED, 16'h0}, "R5 sien1");

    // R6 R7
    @(negedge clk); irq_lvl_i = 2'b01;
    @(negedge clk);
    check("R7 irq from ch0", {31'b0, irq_o}, 1);
    rd(9'h0A0, 32'h6515_0800, "R6 cfg0 bit11");
    rd(9'h0E0, 32'h6515_0000, "R6 cfg1 clear");
    // R8
    dma_cmd_i = 16'h8209; dma_sts_i = 16'h0564;
    e = {8'h05, 8'h64, 1'b0, 1'b1, 6'b0, 8'h09 | 8'h10};
    rd(9'h010, e, "R8 summary ch0 irq");
    // R9
    rd(9'h018, {8'h00, 8'h05, 8'h00, 8'h82}, "R9 summary1 no irq");
    @(negedge clk); irq_lvl_i = 2'b10; dma_sts_i = 16'h0164;
    @(negedge clk);
    check("R7 irq from ch1", {31'b0, irq_o}, 1);
    rd(9'h0E0, 32'h6515_0800, "R6 cfg1 bit11");
    rd(9'h010, {8'h01, 8'h64, 8'h00, 8'h09 | 8'h40}, "R8 summary ch1 irq");
    rd(9'h018, {8'h00, 8'h01, 8'h00, 8'h82 | 8'h10}, "R9 summary1 irq");
    @(negedge clk); irq_lvl_i = 2'b00;
    @(negedge clk);
    check("R7 irq low", {31'b0, irq_o}, 0);

    // R10
    drive_present_i = 2'b01;
    rd(9'h104, 32'h113, "R10 link0 up");
    rd(9'h184, 0, "R10 link1 down");

    // R11
    dma_prd_i = 64'hCAFE_0010_1234_5678;
    rd(9'h000, 32'h09, "R11 cmd0");
    rd(9'h008, 32'h82, "R11 cmd1");
    rd(9'h002, 32'h64, "R11 sts0");
    rd(9'h00A, 32'h01, "R11 sts1");
    rd(9'h004, 32'h1234_5678, "R11 prd0");
    rd(9'h00C, 32'hCAFE_0010, "R11 prd1");
    rd(9'h003, 0, "R11 zero 03");
    rd(9'h00B, 0, "R11 zero 0B");

    // R12
    wr(9'h010, 32'h1, 4'h1);
    check("R12 cmd0 strobe", {30'b0, dma_cmd_we_o}, 1);
    @(negedge clk);
    check("R12 cmd0 one cycle", {30'b0, dma_cmd_we_o}, 0);
    wr(9'h01A, 32'h4, 4'h1);
    check("R12 sts1 strobe", {30'b0, dma_sts_we_o}, 2);
    wr(9'h00C, 32'h0, 4'hC);
    check("R12 prd1 strobe", {30'b0, dma_prd_we_o}, 2);
    wr(9'h002, 32'h4, 4'h1);
    check("R12 sts0 strobe", {30'b0, dma_sts_we_o}, 1);

    // R13
    wr(9'h0F0, 32'hFFFF_FFFF, 4'hF);
    check("R13 no strobes", {24'b0, dma_cmd_we_o, dma_sts_we_o, dma_prd_we_o, chan_rst_o}, 0);
    rd(9'h1FF, 0, "R13 unmapped read");
    rd(9'h100, 32'h0000_05A0, "R13 sctl0 untouched");
    rd(9'h001, 32'h3F, "R13 swd0 untouched");

    // R14
    rd(9'h0A0, 32'h6515_0000, "R14 read");
    bus_addr = 9'h104;
    @(negedge clk);
    @(negedge clk);
    check("R14 hold", bus_rdata, 32'h6515_0000);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule